// File: doc/BRIEF.md
# Alarm Match and Interrupt Status Unit

This block sits beside the timekeeping core of a real-time clock. When the core finishes a one-second update, it pulses a done strobe while presenting the freshly updated seconds, minutes and hours. At that point the block compares the three values against three alarm fields. An alarm field whose two top bits are both set acts as a "don't care" and matches any value.

Three event sources feed one 8-bit status register:
- the alarm match,
- the update-ended event,
- a periodic strobe from the rate generator.

Each source has its own sticky flag, and a shared request bit is set whenever any flag is set. The interrupt output follows the request bit. A host read of the status register returns its contents and clears it. The block does not count time or generate the periodic rate.

Top module: `rtc_event_flags`

## Requirements
- R1: After reset, stat_o reads 0x00 and irq_o is low.
- R2: With alm_en_i low, an update never sets the alarm flag (bit 5).
- R3: An alarm field whose bits 7 and 6 are both 1 matches any current value of that field.
- R4: An alarm field that is not a wildcard matches only when it equals the current field exactly.
- R5: When alm_en_i is high and all three fields match, the update sets bits 7 and 5 of stat_o from the next cycle on. A mismatch in any one field leaves bit 5 unchanged.
- R6: When upd_en_i is high, every update strobe sets bits 7 and 4 from the next cycle on.
- R7: A periodic strobe per_evt_i sets bits 7 and 6 from the next cycle on.
- R8: The time and alarm inputs are compared only in a cycle where upd_done_i is high. In other cycles a match has no effect.
- R9: Flags stay set until a read. In a cycle with stat_rd_i high, stat_o shows the current flags, and the register is cleared from the next cycle on.
- R10: A flag raised in the same cycle as a read is kept and appears after the clear.
- R11: Bits 3..0 of stat_o always read 0.
- R12: irq_o is high exactly when bit 7 of stat_o is high, and it rises only after an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| upd_done_i | input | 1 | One-cycle strobe: a time update has completed |
| sec_i | input | 8 | Freshly updated seconds |
| min_i | input | 8 | Freshly updated minutes |
| hour_i | input | 8 | Freshly updated hours |
| alm_sec_i | input | 8 | Seconds alarm field |
| alm_min_i | input | 8 | Minutes alarm field |
| alm_hour_i | input | 8 | Hours alarm field |
| alm_en_i | input | 1 | Alarm interrupt enable |
| upd_en_i | input | 1 | Update-ended interrupt enable |
| per_evt_i | input | 1 | One-cycle periodic event strobe |
| stat_rd_i | input | 1 | Host read of the status register (read-clear) |
| stat_o | output | 8 | Status register value |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets alarm fields that have only one of the two wildcard bits set. A design that tested a single bit would match these wrongly. It also targets alarms where exactly one of the three fields mismatches, which catches an OR in place of an AND.

A second group of cases hits the cycle where a read coincides with an update or periodic strobe. A design that let the clear win would silently drop that event.

Match values are also presented in cycles without a done strobe, and with the enable low. A design that compared continuously would raise spurious alarms.

Throughout, stat_o and irq_o are checked against a cycle model, so any lost, extra or early flag shows up as a miscompare.

// File: rtl/rtc_flags_pkg.sv
package rtc_flags_pkg;
  parameter int unsigned FIELD_W  = 8;
  parameter int unsigned N_FIELDS = 3;
  parameter int unsigned STAT_W   = 8;
  localparam int unsigned N_FLAGS = 4;
  localparam int unsigned LOW_W   = STAT_W - N_FLAGS;

  // flag vector index; stat_o places it at [STAT_W-1 -: N_FLAGS]
  localparam int unsigned F_UPD = 0;  // bit 4
  localparam int unsigned F_ALM = 1;  // bit 5
  localparam int unsigned F_PER = 2;  // bit 6
  localparam int unsigned F_REQ = 3;  // bit 7

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [N_FLAGS-1:0] flags_t;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import rtc_flags_pkg::*;
(
  input  field_t alm_i,
  input  field_t cur_i,
  output logic   hit_o
);
  logic wild;
  assign wild  = &alm_i[FIELD_W-1 -: 2];
  assign hit_o = wild | (alm_i == cur_i);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_flags_pkg::*;
(
  input  field_t alm_i [N_FIELDS],
  input  field_t cur_i [N_FIELDS],
  output logic   match_o
);
  logic [N_FIELDS-1:0] hit;

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    alarm_field_cmp u_cmp (
      .alm_i (alm_i[g]),
      .cur_i (cur_i[g]),
      .hit_o (hit[g])
    );
  end

  assign match_o = &hit;
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import rtc_flags_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   set_upd_i,
  input  logic   set_alm_i,
  input  logic   set_per_i,
  input  logic   clr_i,
  output flags_t flags_o
);
  flags_t flags_q, flags_d, set_vec;

  always_comb begin
    set_vec        = '0;
    set_vec[F_UPD] = set_upd_i;
    set_vec[F_ALM] = set_alm_i;
    set_vec[F_PER] = set_per_i;
    set_vec[F_REQ] = set_upd_i | set_alm_i | set_per_i;
    // new events win over the read-clear
    flags_d = (clr_i ? '0 : flags_q) | set_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
  import rtc_flags_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_done_i,
  input  logic [7:0]        sec_i,
  input  logic [7:0]        min_i,
  input  logic [7:0]        hour_i,
  input  logic [7:0]        alm_sec_i,
  input  logic [7:0]        alm_min_i,
  input  logic [7:0]        alm_hour_i,
  input  logic              alm_en_i,
  input  logic              upd_en_i,
  input  logic              per_evt_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o
);
  field_t alm_arr [N_FIELDS];
  field_t cur_arr [N_FIELDS];
  logic   match;
  flags_t flags;

  assign alm_arr[0] = alm_sec_i;
  assign alm_arr[1] = alm_min_i;
  assign alm_arr[2] = alm_hour_i;
  assign cur_arr[0] = sec_i;
  assign cur_arr[1] = min_i;
  assign cur_arr[2] = hour_i;

  alarm_match u_match (
    .alm_i   (alm_arr),
    .cur_i   (cur_arr),
    .match_o (match)
  );

  evt_status_reg u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_upd_i (upd_done_i & upd_en_i),
    .set_alm_i (upd_done_i & alm_en_i & match),
    .set_per_i (per_evt_i),
    .clr_i     (stat_rd_i),
    .flags_o   (flags)
  );

  assign stat_o = {flags, {LOW_W{1'b0}}};
  assign irq_o  = flags[F_REQ];
endmodule

// File: rtl/rtc_event_flags_chk.sv
module rtc_event_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       upd_done_i,
  input logic       alm_en_i,
  input logic       upd_en_i,
  input logic       per_evt_i,
  input logic       stat_rd_i,
  input logic [7:0] stat_o,
  input logic       irq_o
);
  p_low_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3:0] == 4'h0);

  p_irq_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(upd_done_i || per_evt_i));

  p_upd_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_i && upd_en_i |=> stat_o[7] && stat_o[4]);

  p_per_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_evt_i |=> stat_o[7] && stat_o[6]);

  p_no_alarm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en_i && !stat_o[5] |=> !stat_o[5]);

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !upd_done_i && !per_evt_i |=> stat_o == 8'h00);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_rd_i && stat_o[5] |=> stat_o[5]);

  p_keep_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && per_evt_i |=> stat_o[6]);
endmodule

bind rtc_event_flags rtc_event_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_done_i (upd_done_i),
  .alm_en_i   (alm_en_i),
  .upd_en_i   (upd_en_i),
  .per_evt_i  (per_evt_i),
  .stat_rd_i  (stat_rd_i),
  .stat_o     (stat_o),
  .irq_o      (irq_o)
);

// File: tb/rtc_event_flags_tb_top.sv
module rtc_event_flags_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       upd_done_i = 1'b0;
  logic [7:0] sec_i = '0, min_i = '0, hour_i = '0;
  logic [7:0] alm_sec_i = '0, alm_min_i = '0, alm_hour_i = '0;
  logic       alm_en_i = 1'b0, upd_en_i = 1'b0, per_evt_i = 1'b0, stat_rd_i = 1'b0;
  logic [7:0] stat_o;
  logic       irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_stat = 8'h00;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  rtc_event_flags dut_i (.*);

  function automatic bit fld_hit(input logic [7:0] a, input logic [7:0] c);
    return (a[7] && a[6]) || (a == c);
  endfunction

  function automatic logic [7:0] model_next(input logic [7:0] cur);
    logic [7:0] n;
    n = stat_rd_i ? 8'h00 : cur;
    if (upd_done_i && upd_en_i) n |= 8'h90;
    if (upd_done_i && alm_en_i && fld_hit(alm_sec_i, sec_i) &&
        fld_hit(alm_min_i, min_i) && fld_hit(alm_hour_i, hour_i)) n |= 8'hA0;
    if (per_evt_i) n |= 8'hC0;
    return n;
  endfunction

  task automatic check(input string req);
    n_chk++;
    if (stat_o !== exp_stat || irq_o !== exp_stat[7]) begin
      n_bad++;
      $display("FAIL %s stat=%h irq=%b expected stat=%h irq=%b",
               req, stat_o, irq_o, exp_stat, exp_stat[7]);
    end
  endtask

  // inputs already driven after a negedge; check, model, advance one cycle
  task automatic cycle(input string req);
    #1;
    check(req);
    exp_stat = model_next(exp_stat);
    @(negedge clk_i);
  endtask

  task automatic idle();
    upd_done_i = 0; per_evt_i = 0; stat_rd_i = 0;
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    sec_i = s; min_i = m; hour_i = h;
  endtask

  task automatic set_alm(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
    alm_sec_i = s; alm_min_i = m; alm_hour_i = h;
  endtask

  task automatic read_clear(input string req);
    idle(); stat_rd_i = 1; cycle(req);
    idle(); cycle(req);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2; check("R1 reset");
    #20; @(negedge clk_i); rst_ni = 1;
    cycle("R1 after reset");

    // R5 exact match, all fields
    alm_en_i = 1; set_alm(8'h30, 8'h15, 8'h09); set_time(8'h30, 8'h15, 8'h09);
    upd_done_i = 1; cycle("R5 match");
    idle(); cycle("R5 flag bits 7,5"); cycle("R9 sticky");
    read_clear("R9 read clear");

    // R5 single-field mismatch each
    for (int f = 0; f < 3; f++) begin
      set_time(8'h30, 8'h15, 8'h09);
      if (f == 0) sec_i = 8'h31; else if (f == 1) min_i = 8'h16; else hour_i = 8'h08;
      upd_done_i = 1; cycle("R4 one field mismatch");
      idle(); cycle("R5 no alarm on mismatch");
    end

    // R3 wildcard and half-wildcards
    set_alm(8'hC0, 8'hFF, 8'h09); set_time(8'h42, 8'h37, 8'h09);
    upd_done_i = 1; cycle("R3 wildcard");
    idle(); cycle("R3 wildcard match");
    read_clear("R9 clear");
    set_alm(8'h80, 8'h40, 8'h09); set_time(8'h42, 8'h37, 8'h09);
    upd_done_i = 1; cycle("R3 half wildcard");
    idle(); cycle("R4 half wildcard no match");

    // R8 no comparison without strobe
    set_alm(8'h30, 8'h15, 8'h09); set_time(8'h30, 8'h15, 8'h09);
    idle(); cycle("R8 no strobe"); cycle("R8 no strobe idle");

    // R2 enable off
    alm_en_i = 0; upd_done_i = 1; cycle("R2 disabled");
    idle(); cycle("R2 no alarm flag");

    // R6 update ended
    upd_en_i = 1; upd_done_i = 1; cycle("R6 update");
    idle(); cycle("R6 bits 7,4");
    // R10 event with read
    stat_rd_i = 1; per_evt_i = 1; cycle("R10 read with periodic");
    idle(); cycle("R10 periodic kept");
    stat_rd_i = 1; upd_done_i = 1; cycle("R10 read with update");
    idle(); cycle("R10 update kept");
    read_clear("R12 irq drops");
    // R7 periodic alone
    upd_en_i = 0; per_evt_i = 1; cycle("R7 periodic");
    idle(); cycle("R7 bits 7,6 R11 low zero");
    read_clear("R9 clear");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] t[3];
      logic [7:0] a[3];
      for (int k = 0; k < 3; k++) begin
        t[k] = 8'($urandom_range(0, 8'h59));
        case ($urandom_range(0, 3))
          0: a[k] = 8'hC0 | 8'($urandom_range(0, 63));
          1: a[k] = 8'($urandom);
          default: a[k] = t[k];
        endcase
      end
      set_time(t[0], t[1], t[2]); set_alm(a[0], a[1], a[2]);
      upd_done_i = ($urandom_range(0, 3) == 0);
      per_evt_i  = ($urandom_range(0, 7) == 0);
      stat_rd_i  = ($urandom_range(0, 5) == 0);
      alm_en_i   = ($urandom_range(0, 3) != 0);
      upd_en_i   = ($urandom_range(0, 1) != 0);
      cycle("R5 R6 R7 R9 R10 R11 R12 random");
    end
    idle(); cycle("R9 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule